// File: doc/BRIEF.md
# Double-Buffered Nine-Bit Serial Transmitter

This block is the send half of a classic microcontroller serial port. A processor-side interface loads a data byte, a ninth-bit value and a double-buffer enable. The block then sends frames on a single TXD line, paced by an external baud tick. It sends a plain 8-bit asynchronous frame, two 9-bit asynchronous frames, and a synchronous shift mode that also drives a shift clock. A sticky transmit flag tells software when it may supply the next byte. Software clears the flag with a strobe.

With double buffering off, the transmitter acts as a single-buffered port. A byte is accepted only while no frame is active. The ninth bit is read from the ninth-bit register at the moment that bit goes out on the line. The flag rises when the frame has been sent. With double buffering on, a holding stage takes the next byte while the current frame is still being sent. The ninth bit is frozen into the holding stage together with the byte. The flag rises as soon as the holding stage empties into the shifter, so it means "buffer free". The held frame follows the previous stop bit with no idle gap. Synchronous shift mode always runs single-buffered, whatever the enable says.

Top module: `uart_dbtx`

## Requirements
- R1: After reset, txd and sclk are high and ti is low.
- R2: In mode 1 a frame is a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts TICKS_PER_BIT baud ticks.
- R3: In modes 2 and 3 the ninth bit is sent between data bit 7 and the stop bit. The frame is 11 bits long.
- R4: With double buffering off, the ninth slot carries the ninth-bit register's value while that slot is on the line, so a ninth-bit write made after the data write still takes effect.
- R5: With double buffering on, the ninth bit of a frame is the ninth-bit register value at the time of the data write. Later ninth-bit writes do not change that frame.
- R6: With double buffering off, ti sets on the clock edge that ends the last bit of the frame.
- R7: With double buffering off, a data write made while a frame is active, or made in the cycle a frame starts, is discarded.
- R8: With double buffering on, a byte written during a frame waits in the holding stage. Its start bit begins on the tick that ends the previous stop bit.
- R9: With double buffering on, ti sets on the edge where the held byte moves into the shifter.
- R10: With double buffering on, a data write while the holding stage is full replaces the held byte and its ninth bit.
- R11: Mode 0 (mode code 0) sends data bits 0 to 7 with no start or stop bit, one bit per baud tick. sclk is low in the first clock cycle of each bit slot. The double-buffer enable is ignored, and ti sets after the eighth bit.
- R12: ti stays high until ti_clr is pulsed. If a set event and ti_clr fall in the same cycle, ti is high afterwards.
- R13: An idle transmitter holding a byte begins the frame on the next baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle baud timing enable |
| mode | input | 2 | Frame mode: 0 shift, 1 eight-bit, 2 and 3 nine-bit |
| dbuf_en | input | 1 | Double-buffer enable (ignored in mode 0) |
| data_wr | input | 1 | Data byte write strobe |
| data_in | input | 8 | Data byte |
| tb8_wr | input | 1 | Ninth-bit register write strobe |
| tb8_in | input | 1 | Ninth-bit value |
| ti_clr | input | 1 | Transmit flag clear strobe |
| txd | output | 1 | Serial data, idle high |
| sclk | output | 1 | Shift clock for mode 0, idle high |
| ti | output | 1 | Transmit flag |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a set event of the transmit flag and the software clear strobe. The second pair is a data write and the transfer of the held byte into the shifter. The bench holds ti_clr high for a whole frame, so the set event lands on a cycle with the clear already active. It also issues data writes on a dense baud-tick grid, which puts writes at the start of frames. A behavioural reference model judges every clock cycle. It applies the set-over-clear rule. It applies the write-during-start rule differently for the two buffer modes: discard when single-buffered, refill the holding stage when double-buffered.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_8BIT  = 2'd1,
    MODE_9FIX  = 2'd2,
    MODE_9VAR  = 2'd3
  } txmode_e;

  localparam int IDX_W = 4;

  // Number of bit slots in one frame of the given mode.
  function automatic logic [IDX_W-1:0] frame_bits(txmode_e m);
    case (m)
      MODE_SHIFT: return 4'd8;
      MODE_8BIT:  return 4'd10;
      default:    return 4'd11;
    endcase
  endfunction

  // Line level for slot idx of a frame carrying byte d and ninth bit nb.
  function automatic logic slot_level(txmode_e m, logic [IDX_W-1:0] idx,
                                      logic [7:0] d, logic nb);
    logic [IDX_W-1:0] k;
    k = idx - 4'd1;
    if (m == MODE_SHIFT) return d[idx[2:0]];
    if (idx == 4'd0) return 1'b0;
    if (idx <= 4'd8) return d[k[2:0]];
    if (idx == 4'd9 && m != MODE_8BIT) return nb;
    return 1'b1;
  endfunction

endpackage

// File: rtl/uart_dbtx_bitclk.sv
module uart_dbtx_bitclk #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  input  logic load,
  input  logic shift_mode,
  output logic bit_end
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  // Shift mode takes one tick per slot; asynchronous modes take TICKS_PER_BIT.
  assign bit_end = tick & busy & (shift_mode | (cnt == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= '0;
    else if (tick & busy) cnt <= bit_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/uart_dbtx_hold.sv
module uart_dbtx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       tb8_wr,
  input  logic       tb8_in,
  input  logic       db_eff,
  input  logic       busy,
  input  logic       load,
  output logic       hold_valid,
  output logic [7:0] hold_data,
  output logic       hold_tb8,
  output logic       tb8_reg,
  output logic       accept,
  output logic       overwrite
);
  // Single-buffered: only an idle, not-starting transmitter takes a byte.
  assign accept    = wr & (db_eff | (~busy & ~load));
  assign overwrite = accept & hold_valid & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      hold_tb8   <= 1'b0;
      tb8_reg    <= 1'b0;
    end else begin
      if (accept) begin
        hold_valid <= 1'b1;
        hold_data  <= wdata;
        hold_tb8   <= tb8_reg;
      end else if (load) begin
        hold_valid <= 1'b0;
      end
      if (tb8_wr) tb8_reg <= tb8_in;
    end
  end
endmodule

// File: rtl/uart_dbtx_shift.sv
module uart_dbtx_shift
  import uart_dbtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       bit_end,
  input  txmode_e    mode_now,
  input  logic       db_eff,
  input  logic [7:0] hold_data,
  input  logic       hold_tb8,
  input  logic       tb8_reg,
  output logic       busy,
  output logic       frame_end,
  output logic       frm_db,
  output logic       frm_shift,
  output logic       txd,
  output logic       sclk
);
  txmode_e          mode_f;
  logic [IDX_W-1:0] idx;
  logic [7:0]       data_f;
  logic             tb8_f;
  logic             sclk_lo;
  logic             ninth;

  assign frm_shift = (mode_f == MODE_SHIFT);
  assign frame_end = bit_end & (idx == frame_bits(mode_f) - 4'd1);
  assign ninth     = frm_db ? tb8_f : tb8_reg;
  assign txd       = busy ? slot_level(mode_f, idx, data_f, ninth) : 1'b1;
  assign sclk      = ~sclk_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      mode_f  <= MODE_8BIT;
      data_f  <= '0;
      tb8_f   <= 1'b0;
      frm_db  <= 1'b0;
      sclk_lo <= 1'b0;
    end else begin
      if (load) begin
        busy   <= 1'b1;
        idx    <= '0;
        mode_f <= mode_now;
        data_f <= hold_data;
        tb8_f  <= hold_tb8;
        frm_db <= db_eff;
      end else if (frame_end) begin
        busy <= 1'b0;
      end else if (bit_end) begin
        idx <= idx + 4'd1;
      end
      sclk_lo <= load ? (mode_now == MODE_SHIFT)
                      : (bit_end & ~frame_end & frm_shift);
    end
  end
endmodule

// File: rtl/uart_dbtx_flag.sv
module uart_dbtx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic ti
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ti <= 1'b0;
    else if (set) ti <= 1'b1;
    else if (clr) ti <= 1'b0;
  end
endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx
  import uart_dbtx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] mode,
  input  logic       dbuf_en,
  input  logic       data_wr,
  input  logic [7:0] data_in,
  input  logic       tb8_wr,
  input  logic       tb8_in,
  input  logic       ti_clr,
  output logic       txd,
  output logic       sclk,
  output logic       ti
);
  txmode_e    mode_now;
  logic       db_eff;
  logic       busy, frame_end, frm_db, frm_shift, bit_end;
  logic       hold_valid, hold_tb8, tb8_reg, accept, overwrite;
  logic [7:0] hold_data;
  logic       load, ti_set;

  assign mode_now = txmode_e'(mode);
  assign db_eff   = dbuf_en & (mode_now != MODE_SHIFT);
  assign load     = hold_valid & baud_tick & (~busy | frame_end);
  assign ti_set   = (load & db_eff) | (frame_end & ~frm_db);

  uart_dbtx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .busy(busy),
    .load(load), .shift_mode(frm_shift), .bit_end(bit_end)
  );

  uart_dbtx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(data_in),
    .tb8_wr(tb8_wr), .tb8_in(tb8_in), .db_eff(db_eff), .busy(busy),
    .load(load), .hold_valid(hold_valid), .hold_data(hold_data),
    .hold_tb8(hold_tb8), .tb8_reg(tb8_reg), .accept(accept),
    .overwrite(overwrite)
  );

  uart_dbtx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .bit_end(bit_end),
    .mode_now(mode_now), .db_eff(db_eff), .hold_data(hold_data),
    .hold_tb8(hold_tb8), .tb8_reg(tb8_reg), .busy(busy),
    .frame_end(frame_end), .frm_db(frm_db), .frm_shift(frm_shift),
    .txd(txd), .sclk(sclk)
  );

  uart_dbtx_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(ti_set), .clr(ti_clr), .ti(ti)
  );
endmodule

// File: rtl/uart_dbtx_chk.sv
module uart_dbtx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic ti,
  input logic ti_clr,
  input logic data_wr,
  input logic load,
  input logic busy,
  input logic db_eff,
  input logic hold_valid,
  input logic frm_shift,
  input logic frame_end,
  input logic ti_set
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && db_eff) |=> !txd);

  p_frame_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !db_eff && !load) |=> (ti && !busy));

  p_single_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy && !db_eff && !load && !hold_valid) |=> !hold_valid);

  p_buffer_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && db_eff) |=> ti);

  p_overwrite_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && db_eff && hold_valid) |=> hold_valid);

  p_ti_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ti_clr) |=> ti);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ti_set |=> ti);

  p_shift_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frm_shift && frame_end && !load) |=> ti);
endmodule

bind uart_dbtx uart_dbtx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .ti(ti), .ti_clr(ti_clr),
  .data_wr(data_wr), .load(load), .busy(busy), .db_eff(db_eff),
  .hold_valid(hold_valid), .frm_shift(frm_shift), .frame_end(frame_end),
  .ti_set(ti_set)
);

// File: tb/uart_dbtx_bench.sv
`timescale 1ns/1ps
module uart_dbtx_bench;
  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       dbuf_en = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       tb8_wr = 1'b0;
  logic       tb8_in = 1'b0;
  logic       ti_clr = 1'b0;
  logic       txd, sclk, ti;

  int    n_tests = 0;
  int    n_fail = 0;
  int    cycles = 0;
  int    tick_div = 2;
  bit    done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  uart_dbtx #(.TICKS_PER_BIT(TPB)) u_uart_dbtx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode),
    .dbuf_en(dbuf_en), .data_wr(data_wr), .data_in(data_in),
    .tb8_wr(tb8_wr), .tb8_in(tb8_in), .ti_clr(ti_clr),
    .txd(txd), .sclk(sclk), .ti(ti)
  );

  // Reference model: slot values in a queue (2 = read ninth-bit register live).
  int m_bitq[$];
  int m_holdq[$];
  int m_left = 0;
  int m_mode = 1;
  bit m_fdb = 0;
  bit m_tb8 = 0;
  bit m_ti = 0;
  bit m_slo = 0;

  always @(posedge clk) begin : model
    bit dbe, busy, bend, fend, load, acc, setv;
    int ent;
    if (!rst_n) begin
      m_bitq.delete(); m_holdq.delete();
      m_left = 0; m_fdb = 0; m_tb8 = 0; m_ti = 0; m_slo = 0; m_mode = 1;
    end else begin
      dbe  = dbuf_en && (mode != 2'd0);
      busy = (m_bitq.size() != 0);
      bend = baud_tick && busy && (m_mode == 0 || m_left == 1);
      fend = bend && (m_bitq.size() == 1);
      load = (m_holdq.size() != 0) && baud_tick && (!busy || fend);
      acc  = data_wr && (dbe || (!busy && !load));
      setv = (load && dbe) || (fend && !m_fdb);
      m_slo = load ? (mode == 2'd0) : (bend && !fend && m_mode == 0);
      if (load) begin
        ent = m_holdq.pop_front();
        m_bitq.delete();
        m_mode = int'(mode);
        m_fdb = dbe;
        m_left = TPB;
        if (m_mode != 0) m_bitq.push_back(0);
        for (int i = 0; i < 8; i++) m_bitq.push_back((ent >> i) & 1);
        if (m_mode >= 2) m_bitq.push_back(dbe ? ((ent >> 8) & 1) : 2);
        if (m_mode != 0) m_bitq.push_back(1);
      end else if (bend) begin
        void'(m_bitq.pop_front());
        m_left = TPB;
      end else if (baud_tick && busy) begin
        m_left = m_left - 1;
      end
      if (acc) begin
        ent = (int'(m_tb8) << 8) | int'(data_in);
        if (m_holdq.size() != 0) m_holdq[0] = ent;
        else m_holdq.push_back(ent);
      end
      if (tb8_wr) m_tb8 = tb8_in;
      m_ti = setv || (m_ti && !ti_clr);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      if (n_fail <= 30)
        $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                 req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin : compare
    int etx;
    cycles++;
    if (rst_n && !done) begin
      etx = (m_bitq.size() == 0) ? 1 : ((m_bitq[0] == 2) ? int'(m_tb8) : m_bitq[0]);
      chk(cur_req, "txd", int'(txd), etx);
      chk(cur_req, "sclk", int'(sclk), int'(!m_slo));
      chk(cur_req, "ti", int'(ti), int'(m_ti));
    end
  end

  initial begin : tickgen
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      if (ph >= tick_div) ph = 0;
      baud_tick = (ph == 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [7:0] d);
    data_in = d; data_wr = 1'b1; cyc(1); data_wr = 1'b0;
  endtask

  task automatic wr_tb8(logic v);
    tb8_in = v; tb8_wr = 1'b1; cyc(1); tb8_wr = 1'b0;
  endtask

  task automatic clr_ti();
    ti_clr = 1'b1; cyc(1); ti_clr = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_bitq.size() != 0 || m_holdq.size() != 0) cyc(1);
    cyc(3);
  endtask

  initial begin : watchdog
    while (cycles < 150000 && !done) @(negedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    cur_req = "R1";
    chk("R1", "reset txd", int'(txd), 1);
    chk("R1", "reset sclk", int'(sclk), 1);
    chk("R1", "reset ti", int'(ti), 0);

    // R2 R13 R6: mode 1 single-buffered frame
    cur_req = "R2";
    mode = 2'd1; dbuf_en = 1'b0;
    wr_byte(8'hA5);
    wait_idle();
    cur_req = "R6";
    chk("R6", "ti after frame", int'(ti), 1);
    clr_ti(); cyc(1);
    chk("R12", "ti cleared", int'(ti), 0);

    // R3 R4 R7: mode 2 single, ninth bit written late, write during frame dropped
    cur_req = "R4";
    mode = 2'd2;
    wr_tb8(1'b0);
    wr_byte(8'h3C);
    cyc(40);
    wr_tb8(1'b1);
    cur_req = "R7";
    wr_byte(8'hFF);
    wait_idle();
    chk("R7", "txd idle after dropped write", int'(txd), 1);
    clr_ti();

    // R3: mode 3 single with ninth bit 1 set beforehand
    cur_req = "R3";
    mode = 2'd3;
    wr_byte(8'h81);
    wait_idle();
    clr_ti();

    // R5 R8 R9: mode 3 double buffered, back-to-back, ninth bit frozen
    cur_req = "R8";
    dbuf_en = 1'b1;
    wr_tb8(1'b1);
    wr_byte(8'h11);
    cyc(6);
    cur_req = "R9";
    chk("R9", "ti after transfer", int'(ti), 1);
    clr_ti();
    cur_req = "R5";
    wr_tb8(1'b0);
    wr_byte(8'h22);
    wr_tb8(1'b1);
    wait_idle();
    clr_ti();

    // R10: overwrite of a full holding stage
    cur_req = "R10";
    mode = 2'd1;
    wr_byte(8'h33);
    cyc(8);
    wr_byte(8'h44);
    cyc(2);
    wr_byte(8'h55);
    wait_idle();
    clr_ti();

    // R11: mode 0 with enable requested, must stay single-buffered
    cur_req = "R11";
    mode = 2'd0; dbuf_en = 1'b1;
    wr_byte(8'h96);
    cyc(3);
    wr_byte(8'h0F);
    wait_idle();
    chk("R11", "ti after shift frame", int'(ti), 1);
    clr_ti();

    // R12: clear held high across a set event
    cur_req = "R12";
    mode = 2'd1; dbuf_en = 1'b0;
    wr_byte(8'h5A);
    ti_clr = 1'b1;
    wait_idle();
    ti_clr = 1'b0;
    cyc(1);
    chk("R12", "ti after clear held", int'(ti), 0);

    // R7 R8: dense ticks with writes at frame start, both buffer modes
    cur_req = "R7";
    tick_div = 1;
    wr_byte(8'hC3);
    wr_byte(8'h3C);
    wait_idle();
    clr_ti();
    cur_req = "R8";
    mode = 2'd2; dbuf_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wr_byte(8'(8'h10 + i));
      cyc(i * 37 + 3);
    end
    wait_idle();
    clr_ti();
    cyc(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule